// File: doc/BRIEF.md
# Smart card character transmitter

This block sends bytes to a smart card over a single half-duplex I/O line. Each character goes out as a low start bit, eight data bits sent least significant bit first, and an even parity bit. The line is then released for a guard window, during which the card may pull the line low to reject the character. The block samples the line in that window. When it sees a rejection, it sends the same byte again without any action from the host. The number of resends is limited by an input. Once that limit is used up, the byte is dropped and a sticky retry-exhausted flag is raised.

Bit timing comes from a clock-enable strobe that pulses twice per elementary time unit (etu). All frame positions below are counted in these half-etu ticks from the tick on which the start bit is driven. The host writes a byte when the transmit-data-empty flag is high. Transmit-data-empty and transmit-end both rise once per byte, after the last attempt. A mode input moves that completion point from 12.5 etu to 11.0 etu after the start edge. The error flag and the retry-exhausted flag are cleared only by the host. Two level interrupt requests are gated by their enable inputs.

Top module: `sc_tx`

## Requirements
- R1: After reset, transmit-data-empty and transmit-end are 1, the error and retry-exhausted flags are 0, and the line drive is released (`line_drv_low_o` = 0). The line drive stays released whenever transmit-data-empty is 1.
- R2: A write while transmit-data-empty is 1 clears transmit-data-empty and transmit-end on the next clock. The start bit is driven on the next half-etu tick. Then D0..D7 (LSB first) and an even parity bit follow, so that the nine bits hold an even number of ones. Each bit lasts two half-etu ticks.
- R3: The line is released 20 half-etu ticks (10 etu) after the start edge. It is sampled for the error signal on tick 21 (10.5 etu), and a low level there counts as an error.
- R4: When no error is seen, transmit-data-empty and transmit-end rise together. This happens on tick 25 (12.5 etu) when `fast_end_i` = 0, and on tick 22 (11.0 etu) when `fast_end_i` = 1.
- R5: When an error is seen, the same byte is sent again with a new start edge on tick 28 after the previous start edge. Transmit-end and transmit-data-empty stay 0 through every resend.
- R6: An error sets the error flag, which holds until `clr_err_i` is asserted. If the hardware set and the host clear fall in the same clock, the set wins.
- R7: `tx_irq_o` is transmit-end AND `tx_irq_en_i`. `err_irq_o` is the error flag AND `err_irq_en_i`.
- R8: After `max_retry_i` resends, a further error ends the byte. On tick 28 of the last attempt, the retry-exhausted flag, transmit-data-empty and transmit-end all rise, and no new start edge follows. `clr_err_i` clears the retry-exhausted flag.
- R9: A write while transmit-data-empty is 0 is ignored. Resends still carry the original byte, and no extra frame follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| half_etu_i | input | 1 | Clock enable, two pulses per etu |
| wr_i | input | 1 | Host byte write strobe |
| wr_data_i | input | 8 | Byte to send |
| fast_end_i | input | 1 | 1: complete at 11.0 etu, 0: at 12.5 etu |
| tx_irq_en_i | input | 1 | Transmit interrupt enable |
| err_irq_en_i | input | 1 | Error interrupt enable |
| clr_err_i | input | 1 | Host clear of error and retry-exhausted flags |
| max_retry_i | input | RETRY_W | Maximum number of resends per byte |
| line_i | input | 1 | Sensed level of the I/O line |
| line_drv_low_o | output | 1 | 1 pulls the I/O line low, 0 releases it |
| tdre_o | output | 1 | Transmit data empty |
| tend_o | output | 1 | Transmit end |
| err_o | output | 1 | Error signal seen (sticky) |
| retry_exh_o | output | 1 | Resend limit used up (sticky) |
| tx_irq_o | output | 1 | Transmit interrupt request |
| err_irq_o | output | 1 | Error interrupt request |

## Verification
The hardware setting of the error flag and the host clear of that flag can land on the same clock. The bench provokes this by asserting `clr_err_i` in exactly the clock that carries the half-etu tick sampling the card's error pulse. It then judges the outcome at the ports: the flag must read 1 afterwards, and the byte must still be resent. A plain clear issued on its own must bring the flag back to 0.

// File: rtl/sc_tx_pkg.sv
`timescale 1ns/1ps
package sc_tx_pkg;
  localparam int unsigned CHAR_BITS = 8;
  localparam int unsigned HALF_MAX  = 2 * (CHAR_BITS + 2) + 8;
  localparam int unsigned HALF_W    = $clog2(HALF_MAX + 1);

  // frame positions in half-etu ticks after the start edge
  localparam logic [HALF_W-1:0] H_RELEASE  = HALF_W'(2 * (CHAR_BITS + 2));
  localparam logic [HALF_W-1:0] H_SAMPLE   = HALF_W'(2 * (CHAR_BITS + 2) + 1);
  localparam logic [HALF_W-1:0] H_END_FAST = HALF_W'(2 * (CHAR_BITS + 2) + 2);
  localparam logic [HALF_W-1:0] H_END_STD  = HALF_W'(2 * (CHAR_BITS + 2) + 5);
  localparam logic [HALF_W-1:0] H_RESEND   = HALF_W'(HALF_MAX);

  typedef enum logic {ST_IDLE, ST_SEND} tx_state_e;
endpackage

// File: rtl/sc_tx_frame.sv
`timescale 1ns/1ps
module sc_tx_frame
  import sc_tx_pkg::*;
#(
  parameter int unsigned RETRY_W = 3
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 half_etu_i,
  input  logic                 load_i,
  input  logic [CHAR_BITS-1:0] load_data_i,
  input  logic                 fast_end_i,
  input  logic [RETRY_W-1:0]   max_retry_i,
  input  logic                 line_i,
  output logic                 drv_low_o,
  output logic                 err_set_o,
  output logic                 done_o,
  output logic                 abort_o
);
  localparam int unsigned IDX_W = $clog2(CHAR_BITS + 1);

  tx_state_e            st_q;
  logic [HALF_W-1:0]    cnt_q;
  logic [CHAR_BITS-1:0] hold_q, shift_q;
  logic                 pend_q, drv_q, seen_q;
  logic [RETRY_W-1:0]   tries_q;

  logic [HALF_W-1:0]    nxt;
  logic [IDX_W-1:0]     bit_idx;
  logic [CHAR_BITS:0]   frame_bits;
  logic                 cur_bit, send_tick, end_ok, give_up;

  assign nxt        = cnt_q + 1'b1;
  assign bit_idx    = IDX_W'(nxt >> 1) - IDX_W'(1);
  assign frame_bits = {^shift_q, shift_q};
  assign cur_bit    = frame_bits[bit_idx];
  assign send_tick  = half_etu_i && (st_q == ST_SEND);
  assign end_ok     = send_tick && !seen_q && (nxt == (fast_end_i ? H_END_FAST : H_END_STD));
  assign give_up    = send_tick && seen_q && (nxt == H_RESEND) && (tries_q == max_retry_i);

  assign err_set_o  = send_tick && (nxt == H_SAMPLE) && !line_i;
  assign done_o     = end_ok || give_up;
  assign abort_o    = give_up;
  assign drv_low_o  = drv_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      cnt_q   <= '0;
      hold_q  <= '0;
      shift_q <= '0;
      pend_q  <= 1'b0;
      drv_q   <= 1'b0;
      seen_q  <= 1'b0;
      tries_q <= '0;
    end else begin
      if (load_i) begin
        hold_q <= load_data_i;
        pend_q <= 1'b1;
      end
      if (half_etu_i) begin
        case (st_q)
          ST_IDLE: if (pend_q) begin
            shift_q <= hold_q;
            pend_q  <= 1'b0;
            drv_q   <= 1'b1;
            cnt_q   <= '0;
            tries_q <= '0;
            seen_q  <= 1'b0;
            st_q    <= ST_SEND;
          end
          ST_SEND: begin
            cnt_q <= nxt;
            if (nxt < H_RELEASE && !nxt[0]) drv_q <= ~cur_bit;
            if (nxt == H_RELEASE) drv_q <= 1'b0;
            if (nxt == H_SAMPLE) seen_q <= ~line_i;
            if (end_ok) st_q <= ST_IDLE;
            if (nxt == H_RESEND && seen_q) begin
              if (tries_q == max_retry_i) begin
                st_q <= ST_IDLE;
              end else begin
                tries_q <= tries_q + 1'b1;
                drv_q   <= 1'b1;
                cnt_q   <= '0;
                seen_q  <= 1'b0;
              end
            end
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/sc_tx_flags.sv
`timescale 1ns/1ps
module sc_tx_flags (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic accept_i,
  input  logic done_i,
  input  logic err_set_i,
  input  logic abort_i,
  input  logic clr_i,
  output logic tdre_o,
  output logic tend_o,
  output logic err_o,
  output logic exh_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tdre_o <= 1'b1;
      tend_o <= 1'b1;
      err_o  <= 1'b0;
      exh_o  <= 1'b0;
    end else begin
      if (accept_i) begin
        tdre_o <= 1'b0;
        tend_o <= 1'b0;
      end else if (done_i) begin
        tdre_o <= 1'b1;
        tend_o <= 1'b1;
      end
      // hardware set has priority over host clear
      if (err_set_i)  err_o <= 1'b1;
      else if (clr_i) err_o <= 1'b0;
      if (abort_i)    exh_o <= 1'b1;
      else if (clr_i) exh_o <= 1'b0;
    end
  end
endmodule

// File: rtl/sc_tx.sv
`timescale 1ns/1ps
module sc_tx
  import sc_tx_pkg::*;
#(
  parameter int unsigned RETRY_W = 3
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 half_etu_i,
  input  logic                 wr_i,
  input  logic [CHAR_BITS-1:0] wr_data_i,
  input  logic                 fast_end_i,
  input  logic                 tx_irq_en_i,
  input  logic                 err_irq_en_i,
  input  logic                 clr_err_i,
  input  logic [RETRY_W-1:0]   max_retry_i,
  input  logic                 line_i,
  output logic                 line_drv_low_o,
  output logic                 tdre_o,
  output logic                 tend_o,
  output logic                 err_o,
  output logic                 retry_exh_o,
  output logic                 tx_irq_o,
  output logic                 err_irq_o
);
  logic accept, err_set, done, abort;

  assign accept = wr_i && tdre_o;

  sc_tx_frame #(.RETRY_W(RETRY_W)) u_frame (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .half_etu_i (half_etu_i),
    .load_i     (accept),
    .load_data_i(wr_data_i),
    .fast_end_i (fast_end_i),
    .max_retry_i(max_retry_i),
    .line_i     (line_i),
    .drv_low_o  (line_drv_low_o),
    .err_set_o  (err_set),
    .done_o     (done),
    .abort_o    (abort)
  );

  sc_tx_flags u_flags (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .accept_i (accept),
    .done_i   (done),
    .err_set_i(err_set),
    .abort_i  (abort),
    .clr_i    (clr_err_i),
    .tdre_o   (tdre_o),
    .tend_o   (tend_o),
    .err_o    (err_o),
    .exh_o    (retry_exh_o)
  );

  assign tx_irq_o  = tend_o && tx_irq_en_i;
  assign err_irq_o = err_o && err_irq_en_i;
endmodule

// File: rtl/sc_tx_chk.sv
`timescale 1ns/1ps
module sc_tx_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic wr_i,
  input logic clr_err_i,
  input logic line_drv_low_o,
  input logic tdre_o,
  input logic tend_o,
  input logic err_o,
  input logic retry_exh_o,
  input logic tx_irq_o
);
  p_idle_released_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tdre_o |-> !line_drv_low_o);

  p_write_clears_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && tdre_o) |=> (!tdre_o && !tend_o));

  p_tend_with_tdre_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tend_o) |-> tdre_o);

  p_tdre_with_tend_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tdre_o) |-> tend_o);

  p_err_sticky_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_o && !clr_err_i) |=> err_o);

  p_txi_needs_tend_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_irq_o |-> tend_o);

  p_exh_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (retry_exh_o && !clr_err_i) |=> retry_exh_o);

  p_exh_completes_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(retry_exh_o) |-> (tend_o && tdre_o));
endmodule

bind sc_tx sc_tx_chk u_chk (.*);

// File: tb/sc_tx_test.sv
`timescale 1ns/1ps
module sc_tx_test;
  localparam int RW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic half_etu = 1'b0, wr = 1'b0, fast_end = 1'b0;
  logic tie = 1'b0, rie = 1'b0, clr = 1'b0, card_low = 1'b0;
  logic [7:0] wr_data = '0;
  logic [RW-1:0] max_retry = '0;
  logic line, drv_low, tdre, tend, err, exh, txi, eri;

  int n_checks = 0, n_errs = 0, cycles = 0;
  int att, bad, endh;
  logic wr_tdre, wr_tend;

  always #2.5 clk = ~clk;
  assign line = ~drv_low & ~card_low;

  sc_tx #(.RETRY_W(RW)) uut (
    .clk_i(clk), .rst_ni(rst_n), .half_etu_i(half_etu), .wr_i(wr),
    .wr_data_i(wr_data), .fast_end_i(fast_end), .tx_irq_en_i(tie),
    .err_irq_en_i(rie), .clr_err_i(clr), .max_retry_i(max_retry),
    .line_i(line), .line_drv_low_o(drv_low), .tdre_o(tdre), .tend_o(tend),
    .err_o(err), .retry_exh_o(exh), .tx_irq_o(txi), .err_irq_o(eri)
  );

  // {data, fast_end, error mask per attempt, max resends}
  localparam logic [15:0] VEC [6] = '{
    {8'hA5, 1'b0, 4'b0000, 3'd3},
    {8'h3C, 1'b1, 4'b0000, 3'd3},
    {8'h01, 1'b0, 4'b0001, 3'd3},
    {8'hFE, 1'b1, 4'b0011, 3'd3},
    {8'h80, 1'b0, 4'b0111, 3'd2},
    {8'h00, 1'b1, 4'b0001, 3'd0}
  };

  task automatic chk(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_errs++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      n_errs++;
      $display("FAIL watchdog: actual %0d expected %0d", cycles, 150000);
      summary();
    end
  end

  task automatic tick(input logic c);
    @(negedge clk) half_etu = 1'b1; clr = c;
    @(negedge clk) half_etu = 1'b0; clr = 1'b0;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic clear_flags();
    @(negedge clk) clr = 1'b1;
    @(negedge clk) clr = 1'b0;
  endtask

  task automatic send_char(input logic [7:0] d, input logic gm, input logic [3:0] emask,
                           input logic [RW-1:0] maxr, input logic clr_race, input logic wr_mid);
    logic in_frame, err_now, exp_b;
    int h;
    fast_end = gm; max_retry = maxr;
    @(negedge clk) wr = 1'b1; wr_data = d;
    @(negedge clk) wr = 1'b0;
    wr_tdre = tdre; wr_tend = tend;
    att = 0; bad = 0; endh = -1; in_frame = 1'b0; h = 0; err_now = 1'b0;
    for (int t = 0; t < 200 && endh < 0; t++) begin
      tick(clr_race && in_frame && h == 20 && att == 1);
      if (in_frame) h++;
      if ((!in_frame || h == 28) && !line) begin
        in_frame = 1'b1; h = 0; att++;
        err_now = (att <= 4) ? emask[att-1] : 1'b0;
      end
      if (in_frame && h >= 3 && h <= 19 && (h % 2) == 1) begin
        int k = (h - 3) / 2;
        exp_b = (k < 8) ? d[k] : ^d;
        if (line !== exp_b) bad++;
      end
      if (in_frame && h == 20) begin
        if (!line) bad++;
        card_low = err_now;
      end
      if (in_frame && h == 23) card_low = 1'b0;
      if (wr_mid && in_frame && h == 5 && att == 1) begin
        @(negedge clk) wr = 1'b1; wr_data = ~d;
        @(negedge clk) wr = 1'b0;
      end
      if (tend && endh < 0) endh = h;
    end
  endtask

  task automatic expect_of(input logic gm, input logic [3:0] emask, input logic [RW-1:0] maxr,
                           output int ea, output int eh, output logic eexh);
    logic fin = 1'b0;
    ea = 0; eh = 0; eexh = 1'b0;
    for (int k = 1; k <= 4; k++) begin
      if (!fin) begin
        if (!emask[k-1]) begin
          ea = k; eh = gm ? 22 : 25; fin = 1'b1;
        end else if (k - 1 == int'(maxr)) begin
          ea = k; eh = 28; eexh = 1'b1; fin = 1'b1;
        end
      end
    end
  endtask

  initial begin
    int ea, eh;
    logic eexh;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 tdre", int'(tdre), 1);
    chk("R1 tend", int'(tend), 1);
    chk("R1 err", int'(err), 0);
    chk("R1 exh", int'(exh), 0);
    chk("R1 line released", int'(drv_low), 0);
    tie = 1'b1; #1;
    chk("R7 txi follows tend", int'(txi), 1);

    foreach (VEC[i]) begin
      clear_flags();
      send_char(VEC[i][15:8], VEC[i][7], VEC[i][6:3], VEC[i][2:0], 1'b0, 1'b0);
      expect_of(VEC[i][7], VEC[i][6:3], VEC[i][2:0], ea, eh, eexh);
      chk("R2 write clears flags", int'(wr_tdre | wr_tend), 0);
      chk("R2/R3 frame bits", bad, 0);
      chk("R5/R8 attempts", att, ea);
      chk("R4/R5/R8 tend tick", endh, eh);
      chk("R6 err flag", int'(err), int'(VEC[i][3]));
      chk("R8 retry exhausted", int'(exh), int'(eexh));
      chk("R4 tdre at end", int'(tdre), 1);
    end

    // R7 interrupt gating (last vector left err = 1)
    rie = 1'b0; #1;
    chk("R7 eri masked", int'(eri), 0);
    rie = 1'b1; #1;
    chk("R7 eri raised", int'(eri), 1);
    tie = 1'b0; #1;
    chk("R7 txi masked", int'(txi), 0);

    // R6 / R8 host clear
    clear_flags();
    chk("R6 clear err", int'(err), 0);
    chk("R8 clear exh", int'(exh), 0);

    // R6 set and clear in the same clock
    send_char(8'h5A, 1'b1, 4'b0001, 3'd3, 1'b1, 1'b0);
    chk("R6 set beats clear", int'(err), 1);
    chk("R5 resend after race", att, 2);
    chk("R4 end after race", endh, 22);

    // R9 write while busy is ignored
    clear_flags();
    send_char(8'hC3, 1'b0, 4'b0001, 3'd3, 1'b0, 1'b1);
    chk("R9 resend keeps byte", bad, 0);
    chk("R9 attempts", att, 2);
    begin
      int lows = 0;
      for (int t = 0; t < 40; t++) begin
        tick(1'b0);
        if (!line) lows++;
      end
      chk("R9 no extra frame", lows, 0);
      chk("R9 tdre stays set", int'(tdre), 1);
    end

    summary();
  end
endmodule